// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that gives a host access to a file of 32 configuration bytes. The rest of the device reads the whole file in parallel, every bit at once. Every byte loads its default value at reset. A system that never uses the bus therefore still has a working setup.

Each transaction starts with the device address. A command byte follows it:

- Its top bit selects one of two modes: single indexed byte access, or block access from byte zero.
- Two bits must be zero, or the slave refuses the transaction.
- The low five bits give the byte index for single access.

A write carries its data directly after the command. A block write sends a byte count first. A read uses a repeated start and the address with the read bit set.

The block samples SCL and SDA with its own clock and assumes both are already synchronous. It pulls SDA low only through an output enable, and changes that enable only while SCL is low. A power-down input makes the slave release SDA and ignore all bus activity.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset every byte of `cfg_regs` equals its default (0xA5 with the default parameters), and `sda_oe` is 0.
- R2: The slave ACKs the address byte 0xD2 (7-bit address 0x69, write). Any other address is NACKed, and the following bytes of that transaction get no ACK and change no register.
- R3: Command bits 6:5 must be 00. With any other value, the command byte is NACKed, and the rest of the transaction gets no ACK and changes no register.
- R4: A command with bit 7 = 1 selects byte access at the offset in bits 4:0. One data byte is stored at that offset, on the clock edge after the SCL fall that ends its eighth bit. A second data byte in the same transaction is NACKed and discarded.
- R5: After a byte-access command, a repeated start and the address byte 0xD3 (read) are ACKed. The slave then sends the byte at the offset, MSB first. Each master ACK makes it send the byte at the next offset. A master NACK makes it release SDA.
- R6: A command with bit 7 = 0 selects block access. In a block write, the byte after the command is a byte count. The data bytes that follow are stored at offsets 0, 1, 2 and so on. A stop after any complete byte keeps the bytes already stored.
- R7: In a block write, a data byte beyond the byte count, or beyond offset 31, is NACKed and not stored.
- R8: In a block read, the first byte sent is the count value 32. The bytes at offsets 0, 1, 2 and so on follow, MSB first, until the master NACKs.
- R9: While `pwr_dn` is high, `sda_oe` stays 0, no byte is ACKed and no register changes.
- R10: The slave changes `sda_oe` only while SCL is low, and `sda_oe` is 0 after a stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to sample the bus |
| rst_n | input | 1 | Active-low reset, loads the defaults |
| pwr_dn | input | 1 | High: release SDA and ignore the bus |
| scl_i | input | 1 | Serial clock, already synchronous |
| sda_i | input | 1 | Resolved serial data line |
| sda_oe | output | 1 | High: pull SDA low |
| cfg_regs | output | 256 | All 32 bytes in parallel, byte i at bits 8i+7:8i |

## Verification
Every decision the slave takes is due on the clock edge after it sees an SCL edge. A stored byte appears on `cfg_regs` on the clock edge after the SCL fall that ends its eighth bit. An ACK, or the next read bit, appears on `sda_oe` at that same point. The bench updates its own image of the register file when it drives that SCL fall, and compares the whole image with `cfg_regs` at every falling clock edge. It therefore expects each write exactly one rising edge after the stimulus. Bus bits (ACKs and read data) are sampled two clocks into SCL high, well after the slave has settled. The bench also checks on every clock that `sda_oe` holds steady while SCL stays high.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter logic [6:0]        DEV_ADDR  = 7'h69,
  parameter int                NREG      = 32,
  parameter logic [NREG*8-1:0] RESET_VAL = {NREG{8'hA5}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_regs
);
  localparam int AW = $clog2(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_RD} st_t;

  st_t        st;
  logic       scl_q, sda_q, in_ack, ack_q, blk, m_nack, send_cnt;
  logic [3:0] bits;
  logic [7:0] sr, remain;
  logic [AW:0] ptr;
  logic [7:0] regs [NREG];

  wire scl_rise  = scl_i & ~scl_q;
  wire scl_fall  = ~scl_i & scl_q;
  wire got_start = scl_i & scl_q & sda_q & ~sda_i;
  wire got_stop  = scl_i & scl_q & ~sda_q & sda_i;
  wire over      = ptr >= (AW+1)'(NREG);
  wire wr_ok     = (remain != 8'd0) && !over;

  assign sda_oe = !pwr_dn && (st != S_IDLE) &&
                  ((in_ack && ack_q) || (st == S_RD && !in_ack && !sr[7]));

  for (genvar g = 0; g < NREG; g++) begin : g_view
    assign cfg_regs[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      in_ack   <= 1'b0;
      ack_q    <= 1'b0;
      blk      <= 1'b0;
      m_nack   <= 1'b0;
      send_cnt <= 1'b0;
      bits     <= '0;
      sr       <= '0;
      remain   <= '0;
      ptr      <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= RESET_VAL[i*8 +: 8];
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (pwr_dn) begin
        st     <= S_IDLE;
        in_ack <= 1'b0;
        ack_q  <= 1'b0;
      end else if (got_start) begin
        st     <= S_ADDR;
        bits   <= '0;
        in_ack <= 1'b0;
        ack_q  <= 1'b0;
      end else if (got_stop) begin
        st     <= S_IDLE;
        in_ack <= 1'b0;
        ack_q  <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (in_ack) m_nack <= sda_i;
          else if (bits != 4'd8) begin
            bits <= bits + 4'd1;
            if (st != S_RD) sr <= {sr[6:0], sda_i};
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            ack_q  <= 1'b0;
            bits   <= '0;
            if (st == S_RD) begin
              if (m_nack) st <= S_IDLE;
              else if (send_cnt) begin
                sr       <= 8'(NREG);
                send_cnt <= 1'b0;
              end else begin
                sr  <= regs[ptr[AW-1:0]];
                ptr <= ptr + 1'b1;
              end
            end
          end else if (bits == 4'd8) begin
            in_ack <= 1'b1;
            case (st)
              S_ADDR:
                if (sr[7:1] == DEV_ADDR) begin
                  ack_q    <= 1'b1;
                  m_nack   <= 1'b0;
                  send_cnt <= blk;
                  st       <= sr[0] ? S_RD : S_CMD;
                end else st <= S_IDLE;
              S_CMD:
                if (sr[6:5] == 2'b00) begin
                  ack_q  <= 1'b1;
                  blk    <= ~sr[7];
                  ptr    <= sr[7] ? (AW+1)'(sr[4:0]) : '0;
                  remain <= sr[7] ? 8'd1 : 8'd0;
                  st     <= sr[7] ? S_WR : S_CNT;
                end else st <= S_IDLE;
              S_CNT: begin
                ack_q  <= 1'b1;
                remain <= sr;
                st     <= S_WR;
              end
              S_WR:
                if (wr_ok) begin
                  ack_q              <= 1'b1;
                  regs[ptr[AW-1:0]]  <= sr;
                  ptr                <= ptr + 1'b1;
                  remain             <= remain - 8'd1;
                end else st <= S_IDLE;
              default: ;
            endcase
          end else if (st == S_RD) begin
            sr <= {sr[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
  parameter int NREG = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_dn,
  input logic              scl_i,
  input logic              sda_i,
  input logic              sda_oe,
  input logic [NREG*8-1:0] cfg_regs
);
  // R9: no pull on SDA during power-down
  a_r9_release_in_pwrdn: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> !sda_oe);

  // R9: register file frozen during power-down
  a_r9_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> $stable(cfg_regs));

  // R4: stores happen only right after an SCL fall
  a_r4_store_on_scl_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(!scl_i && $past(scl_i)) |=> $stable(cfg_regs));

  // R10: drive changes only while SCL is low
  a_r10_oe_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !pwr_dn) |=> ($stable(sda_oe) || pwr_dn));

  // R10: stop leaves SDA released
  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> !sda_oe);
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .scl_i(scl_i),
  .sda_i(sda_i), .sda_oe(sda_oe), .cfg_regs(cfg_regs)
);

// File: tb/tb_smb_cfg_slave.sv
module tb_smb_cfg_slave;
  localparam int NREG = 32;

  logic clk = 1'b0, rst_n = 1'b0, pwr_dn = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_regs;
  wire  sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  smb_cfg_slave dut (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .scl_i(scl_m),
    .sda_i(sda_bus), .sda_oe(sda_oe), .cfg_regs(cfg_regs)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] model [NREG];
  logic last_scl = 1'b1, last_oe = 1'b0, last_pd = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      int bad = -1;
      for (int i = NREG - 1; i >= 0; i--)
        if (cfg_regs[i*8 +: 8] !== model[i]) bad = i;
      if (bad < 0) chk(1'b1, "R4 R6 R7 register image", 0, 0);
      else chk(1'b0, "R4 R6 R7 register image", int'(cfg_regs[bad*8 +: 8]), int'(model[bad]));
      if (pwr_dn) chk(sda_oe == 1'b0, "R9 SDA released in power-down", sda_oe, 0);
      if (scl_m && last_scl && !pwr_dn && !last_pd)
        chk(sda_oe === last_oe, "R10 drive steady while SCL high", sda_oe, last_oe);
    end
    last_scl = scl_m;
    last_oe  = sda_oe;
    last_pd  = pwr_dn;
  endtask

  task automatic ticks(input int n);
    repeat (n) tick();
  endtask

  task automatic start_c();
    scl_m = 1'b0; ticks(2);
    sda_m = 1'b1; ticks(2);
    scl_m = 1'b1; ticks(4);
    sda_m = 1'b0; ticks(4);
  endtask

  task automatic stop_c();
    scl_m = 1'b0; ticks(2);
    sda_m = 1'b0; ticks(2);
    scl_m = 1'b1; ticks(4);
    sda_m = 1'b1; ticks(4);
    chk(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
  endtask

  task automatic bit_io(input logic b, output logic s);
    scl_m = 1'b0; ticks(2);
    sda_m = b;    ticks(2);
    scl_m = 1'b1; ticks(2);
    s = sda_bus;  ticks(2);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit wr_en, input int idx, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    scl_m = 1'b0;
    if (wr_en) model[idx] = b;
    ticks(2);
    sda_m = 1'b1; ticks(2);
    scl_m = 1'b1; ticks(2);
    ack = !sda_bus;
    ticks(2);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bit_io(1'b1, s);
      d = {d[6:0], s};
    end
    bit_io(nack, s);
  endtask

  task automatic byte_write(input int off, input logic [7:0] v, input string req);
    bit a;
    start_c();
    send_byte(8'hD2, 0, 0, a);                  chk(a, {req, " address ACK"}, a, 1);
    send_byte(8'h80 | 8'(off), 0, 0, a);        chk(a, {req, " command ACK"}, a, 1);
    send_byte(v, 1, off, a);                    chk(a, {req, " data ACK"}, a, 1);
    stop_c();
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) model[i] = 8'hA5;
    ticks(5);
    rst_n = 1'b1;
    ticks(2);

    // R1: defaults and idle bus
    for (int i = 0; i < NREG; i++)
      chk(cfg_regs[i*8 +: 8] == 8'hA5, "R1 default byte", int'(cfg_regs[i*8 +: 8]), 'hA5);
    chk(sda_oe == 1'b0, "R1 SDA released after reset", sda_oe, 0);

    // R4: byte write, then a second data byte is refused
    start_c();
    send_byte(8'hD2, 0, 0, a);  chk(a, "R2 address 0xD2 ACK", a, 1);
    send_byte(8'h85, 0, 0, a);  chk(a, "R4 byte command ACK", a, 1);
    send_byte(8'h3C, 1, 5, a);  chk(a, "R4 data ACK", a, 1);
    send_byte(8'h77, 0, 0, a);  chk(!a, "R4 extra byte NACK", a, 0);
    stop_c();

    // R5: byte read
    start_c();
    send_byte(8'hD2, 0, 0, a);
    send_byte(8'h85, 0, 0, a);
    start_c();
    send_byte(8'hD3, 0, 0, a);  chk(a, "R5 read address ACK", a, 1);
    recv_byte(1'b1, d);         chk(d == 8'h3C, "R5 read byte 5", d, 'h3C);
    stop_c();

    // R5: consecutive read from offset 30
    byte_write(30, 8'h5A, "R4");
    byte_write(31, 8'hC3, "R4");
    start_c();
    send_byte(8'hD2, 0, 0, a);
    send_byte(8'h9E, 0, 0, a);
    start_c();
    send_byte(8'hD3, 0, 0, a);
    recv_byte(1'b0, d);         chk(d == 8'h5A, "R5 read offset 30", d, 'h5A);
    recv_byte(1'b1, d);         chk(d == 8'hC3, "R5 read offset 31", d, 'hC3);
    stop_c();

    // R2: foreign address
    start_c();
    send_byte(8'hD4, 0, 0, a);  chk(!a, "R2 address 0xD4 NACK", a, 0);
    send_byte(8'h85, 0, 0, a);  chk(!a, "R2 ignored after NACK", a, 0);
    send_byte(8'h99, 0, 0, a);  chk(!a, "R2 data ignored", a, 0);
    stop_c();

    // R3: chip-select field nonzero
    start_c();
    send_byte(8'hD2, 0, 0, a);
    send_byte(8'hA5, 0, 0, a);  chk(!a, "R3 cs=01 NACK", a, 0);
    send_byte(8'h11, 0, 0, a);  chk(!a, "R3 data ignored", a, 0);
    stop_c();
    start_c();
    send_byte(8'hD2, 0, 0, a);
    send_byte(8'h40, 0, 0, a);  chk(!a, "R3 cs=10 block NACK", a, 0);
    stop_c();

    // R6 and R7: block write of 4, fifth byte refused
    start_c();
    send_byte(8'hD2, 0, 0, a);
    send_byte(8'h00, 0, 0, a);  chk(a, "R6 block command ACK", a, 1);
    send_byte(8'd4, 0, 0, a);   chk(a, "R6 count ACK", a, 1);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'(8'h11 * (i + 1)), 1, i, a);
      chk(a, "R6 block data ACK", a, 1);
    end
    send_byte(8'h55, 0, 0, a);  chk(!a, "R7 byte past count NACK", a, 0);
    stop_c();

    // R6: early stop keeps stored bytes
    start_c();
    send_byte(8'hD2, 0, 0, a);
    send_byte(8'h00, 0, 0, a);
    send_byte(8'd10, 0, 0, a);
    send_byte(8'hAA, 1, 0, a);  chk(a, "R6 early data ACK", a, 1);
    send_byte(8'hBB, 1, 1, a);  chk(a, "R6 early data ACK", a, 1);
    stop_c();

    // R7: count larger than the file
    start_c();
    send_byte(8'hD2, 0, 0, a);
    send_byte(8'h00, 0, 0, a);
    send_byte(8'd40, 0, 0, a);
    for (int i = 0; i < 33; i++) begin
      send_byte(8'(i * 7 + 1), i < NREG, i, a);
      chk(a == (i < NREG), "R7 ACK up to offset 31 only", a, i < NREG);
    end
    stop_c();

    // R8: full block read
    start_c();
    send_byte(8'hD2, 0, 0, a);
    send_byte(8'h00, 0, 0, a);
    start_c();
    send_byte(8'hD3, 0, 0, a);  chk(a, "R8 read address ACK", a, 1);
    recv_byte(1'b0, d);         chk(d == 8'd32, "R8 count byte", d, 32);
    for (int i = 0; i < NREG; i++) begin
      recv_byte(i == NREG - 1, d);
      chk(d == model[i], "R8 block data", d, int'(model[i]));
    end
    stop_c();

    // R8: short block read
    start_c();
    send_byte(8'hD2, 0, 0, a);
    send_byte(8'h00, 0, 0, a);
    start_c();
    send_byte(8'hD3, 0, 0, a);
    recv_byte(1'b0, d);         chk(d == 8'd32, "R8 count byte short", d, 32);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i == 2, d);
      chk(d == model[i], "R8 short block data", d, int'(model[i]));
    end
    stop_c();

    // R9: power-down ignores a full write
    pwr_dn = 1'b1;
    ticks(2);
    start_c();
    send_byte(8'hD2, 0, 0, a);  chk(!a, "R9 no ACK in power-down", a, 0);
    send_byte(8'h85, 0, 0, a);  chk(!a, "R9 no ACK in power-down", a, 0);
    send_byte(8'h00, 0, 0, a);  chk(!a, "R9 no ACK in power-down", a, 0);
    stop_c();
    pwr_dn = 1'b0;
    ticks(4);
    byte_write(5, 8'h0F, "R9 recovery");

    ticks(8);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule